// File: doc/BRIEF.md
# SPI Packet FIFO Pair with Status and DMA Triggers

This block holds the two packet queues of an SPI controller: a transmit queue that the register bus fills and the serial shift engine drains, and a receive queue that the shift engine fills and the register bus drains. Each queue holds 64 packets by default. A 32-bit status word reports the fill levels, live full and empty flags, and sticky overflow and underrun flags for both queues. Writing that word clears the sticky flags and starts flush operations, which clear themselves when they finish.

A small control word enables DMA requests. It also sets, for each direction, the packet threshold at which the request is raised. The DMA engine and the serial shifting are outside this block.

All four data paths use valid/ready. Ready on a push side and valid on a pop side are advisory: they equal "not full" and "not empty". A push offered while ready is low is dropped and flagged as an overflow. A pop requested while valid is low returns zero and is flagged as an underrun. A transfer completes on any clock edge where valid and ready are both high.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset both queues are empty. The status word reads 0x0040_0005, the control word reads 0, and both DMA requests are low.
- R2: Each queue returns packets in the order they were accepted. A packet moves on a clock edge where its valid and ready are both high.
- R3: Status bits 29:23 hold the number of packets in the receive queue. Bits 22:16 hold the number of free slots in the transmit queue. A push without a pop raises the fill level by one on the next edge.
- R4: Status bit 3 shows transmit full and bit 2 shows transmit empty. Bit 1 shows receive full and bit 0 shows receive empty. Every push-side ready equals "not full" and every pop-side valid equals "not empty".
- R5: A push offered to a full queue is dropped and the queue contents stay unchanged. The push sets a sticky overflow flag: bit 7 for transmit, bit 5 for receive.
- R6: A pop requested from an empty queue returns zero data. It sets a sticky underrun flag: bit 6 for transmit, bit 4 for receive.
- R7: Status bit 8 is the OR of bits 7:4. Writing the status word with 1 in any of bits 7:4 clears that flag, and a 1 in bit 8 clears all four. If a flag-setting event and a clearing write fall in the same cycle, the flag stays set.
- R8: Writing the status word with bit 15 set flushes the receive queue, and bit 14 flushes the transmit queue. The bit reads 1 for the cycle after the write. On the following edge the queue is emptied and the bit reads 0. A flush leaves the other queue and the sticky flags untouched. A push or pop offered during the flush cycle is discarded and raises no flag.
- R9: Control word (address 1), read back as written: bit 0 enables DMA requests, bits 2:1 set the transmit trigger and bits 4:3 set the receive trigger. Trigger codes 0, 1, 2 and 3 mean 1, 4, 8 and 16 packets.
- R10: While DMA requests are enabled, the transmit request is high when the free slots are at or above the transmit threshold. The receive request is high when the fill level is at or above the receive threshold. Both requests are low while DMA requests are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 1 | 0 selects the status word, 1 selects the control word |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for the selected word |
| txw_valid | input | 1 | Bus offers a transmit packet |
| txw_ready | output | 1 | Transmit queue not full |
| txw_data | input | DATA_W | Transmit packet from the bus |
| txr_valid | output | 1 | Transmit queue not empty |
| txr_ready | input | 1 | Shift engine takes a transmit packet |
| txr_data | output | DATA_W | Head transmit packet, zero when empty |
| rxw_valid | input | 1 | Shift engine offers a received packet |
| rxw_ready | output | 1 | Receive queue not full |
| rxw_data | input | DATA_W | Received packet from the shift engine |
| rxr_valid | output | 1 | Receive queue not empty |
| rxr_ready | input | 1 | Bus takes a received packet |
| rxr_data | output | DATA_W | Head received packet, zero when empty |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
Two things can happen in the same clock: an underrun or overflow event that sets a sticky flag, and a status write that clears that same flag. The bench provokes this by requesting a pop from the empty receive queue in the cycle that carries a write of 1 to bit 4. It passes only if bit 4 still reads 1 afterwards. A similar collision is a push offered in the flush cycle. That push must vanish without raising the overflow flag, and the queue must read empty.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int STAT_RX_CNT_LSB = 23;
  localparam int STAT_TX_FREE_LSB = 16;
  localparam int STAT_RX_FLUSH = 15;
  localparam int STAT_TX_FLUSH = 14;
  localparam int STAT_ERR = 8;
  localparam int STAT_FIELD_W = 7;

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_16 = 2'd3
  } trig_e;

  typedef struct packed {
    logic [1:0] rx_trig;
    logic [1:0] tx_trig;
    logic       dma_en;
  } dma_ctl_t;

  function automatic int unsigned trig_threshold(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (4 << (code - 2'd1));
  endfunction
endpackage

// File: rtl/spi_pkt_fifo.sv
module spi_pkt_fifo #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  output logic              pop_valid,
  input  logic              pop_ready,
  output logic [DATA_W-1:0] pop_data,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty,
  output logic              ovf_evt,
  output logic              unr_evt
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign full       = (count == CW'(DEPTH));
  assign empty      = (count == '0);
  assign push_ready = ~full;
  assign pop_valid  = ~empty;
  assign do_push    = push_valid & ~full & ~flush;
  assign do_pop     = pop_ready & ~empty & ~flush;
  assign ovf_evt    = push_valid & full & ~flush;
  assign unr_evt    = pop_ready & empty & ~flush;
  assign pop_data   = empty ? '0 : mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_dma_trig.sv
module spi_dma_trig #(
  parameter int CW = 7
) (
  input  logic          enable,
  input  logic [1:0]    code,
  input  logic [CW-1:0] level,
  output logic          req
);
  import spi_fifo_pkg::*;
  logic [CW-1:0] thr;
  assign thr = CW'(trig_threshold(code));
  assign req = enable && (level >= thr);
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic              csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              txw_valid,
  output logic              txw_ready,
  input  logic [DATA_W-1:0] txw_data,
  output logic              txr_valid,
  input  logic              txr_ready,
  output logic [DATA_W-1:0] txr_data,
  input  logic              rxw_valid,
  output logic              rxw_ready,
  input  logic [DATA_W-1:0] rxw_data,
  output logic              rxr_valid,
  input  logic              rxr_ready,
  output logic [DATA_W-1:0] rxr_data,
  output logic              tx_dma_req,
  output logic              rx_dma_req
);
  import spi_fifo_pkg::*;

  logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_ovf_e, tx_unr_e, rx_ovf_e, rx_unr_e;
  logic tx_flush_q, rx_flush_q;
  logic [3:0] sticky;
  logic [3:0] sticky_clr;
  dma_ctl_t ctl_q;
  logic wr_stat, wr_ctl;
  logic [31:0] stat_word;

  spi_pkt_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_txq (
    .clk, .rst_n, .flush(tx_flush_q),
    .push_valid(txw_valid), .push_ready(txw_ready), .push_data(txw_data),
    .pop_valid(txr_valid), .pop_ready(txr_ready), .pop_data(txr_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .ovf_evt(tx_ovf_e), .unr_evt(tx_unr_e)
  );

  spi_pkt_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rxq (
    .clk, .rst_n, .flush(rx_flush_q),
    .push_valid(rxw_valid), .push_ready(rxw_ready), .push_data(rxw_data),
    .pop_valid(rxr_valid), .pop_ready(rxr_ready), .pop_data(rxr_data),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .ovf_evt(rx_ovf_e), .unr_evt(rx_unr_e)
  );

  assign tx_free = CW'(DEPTH) - tx_cnt;

  spi_dma_trig #(.CW(CW)) u_tx_trig (
    .enable(ctl_q.dma_en), .code(ctl_q.tx_trig), .level(tx_free), .req(tx_dma_req)
  );
  spi_dma_trig #(.CW(CW)) u_rx_trig (
    .enable(ctl_q.dma_en), .code(ctl_q.rx_trig), .level(rx_cnt), .req(rx_dma_req)
  );

  assign wr_stat    = csr_we && (csr_addr == 1'b0);
  assign wr_ctl     = csr_we && (csr_addr == 1'b1);
  assign sticky_clr = wr_stat ? (csr_wdata[7:4] | {4{csr_wdata[STAT_ERR]}}) : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky     <= '0;
      tx_flush_q <= 1'b0;
      rx_flush_q <= 1'b0;
      ctl_q      <= '0;
    end else begin
      sticky     <= (sticky & ~sticky_clr) | {tx_ovf_e, tx_unr_e, rx_ovf_e, rx_unr_e};
      tx_flush_q <= wr_stat & csr_wdata[STAT_TX_FLUSH];
      rx_flush_q <= wr_stat & csr_wdata[STAT_RX_FLUSH];
      if (wr_ctl) ctl_q <= dma_ctl_t'(csr_wdata[4:0]);
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[STAT_RX_CNT_LSB +: STAT_FIELD_W]  = STAT_FIELD_W'(rx_cnt);
    stat_word[STAT_TX_FREE_LSB +: STAT_FIELD_W] = STAT_FIELD_W'(tx_free);
    stat_word[STAT_RX_FLUSH] = rx_flush_q;
    stat_word[STAT_TX_FLUSH] = tx_flush_q;
    stat_word[STAT_ERR]      = |sticky;
    stat_word[7:4]           = sticky;
    stat_word[3:0]           = {tx_full, tx_empty, rx_full, rx_empty};
  end

  assign csr_rdata = csr_addr ? {27'b0, ctl_q} : stat_word;
endmodule

// File: rtl/spi_fifo_pair_chk.sv
module spi_fifo_pair_chk #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int CW     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txw_valid,
  input logic              txw_ready,
  input logic              rxw_valid,
  input logic              rxw_ready,
  input logic              rxr_valid,
  input logic              rxr_ready,
  input logic [DATA_W-1:0] rxr_data,
  input logic              tx_flush,
  input logic              rx_flush,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic [3:0]        sticky,
  input logic              dma_en,
  input logic              tx_dma_req,
  input logic              rx_dma_req
);
  AST_TX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    txw_valid && !txw_ready && !tx_flush |=> sticky[3]); // R5
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rxr_ready && !rxr_valid |-> rxr_data == '0); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_cnt == '0); // R8
  AST_RX_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    rxw_valid && rxw_ready && !(rxr_valid && rxr_ready) && !rx_flush
    |=> rx_cnt == $past(rx_cnt) + 1'b1); // R3
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH)); // R4
  AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dma_req || rx_dma_req) |-> dma_en); // R10
endmodule

bind spi_fifo_pair spi_fifo_pair_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .txw_valid(txw_valid), .txw_ready(txw_ready),
  .rxw_valid(rxw_valid), .rxw_ready(rxw_ready),
  .rxr_valid(rxr_valid), .rxr_ready(rxr_ready), .rxr_data(rxr_data),
  .tx_flush(tx_flush_q), .rx_flush(rx_flush_q),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .sticky(sticky),
  .dma_en(ctl_q.dma_en), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
);

// File: tb/spi_fifo_pair_bench.sv
module spi_fifo_pair_bench;
  logic clk = 0, rst_n = 0;
  logic csr_we = 0, csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic txw_valid = 0, txw_ready, txr_valid, txr_ready = 0;
  logic rxw_valid = 0, rxw_ready, rxr_valid, rxr_ready = 0;
  logic [7:0] txw_data = 0, txr_data, rxw_data = 0, rxr_data;
  logic tx_dma_req, rx_dma_req;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_fifo_pair u_spi_fifo_pair (.*);

  typedef struct packed {
    logic [4:0] ctl;
    logic [6:0] nrx;
    logic [6:0] ntx;
    logic       erx;
    logic       etx;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{5'h1E, 7'd20, 7'd0,  1'b0, 1'b0},
    '{5'h01, 7'd1,  7'd63, 1'b1, 1'b1},
    '{5'h0B, 7'd3,  7'd61, 1'b0, 1'b0},
    '{5'h0B, 7'd4,  7'd60, 1'b1, 1'b1},
    '{5'h15, 7'd7,  7'd57, 1'b0, 1'b0},
    '{5'h15, 7'd8,  7'd56, 1'b1, 1'b1},
    '{5'h1F, 7'd15, 7'd49, 1'b0, 1'b0},
    '{5'h1F, 7'd16, 7'd48, 1'b1, 1'b1},
    '{5'h07, 7'd0,  7'd0,  1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat(input int nrx, input int ntx);
    logic [31:0] v;
    v = (32'(nrx) << 23) | (32'(64 - ntx) << 16);
    if (ntx == 64) v[3] = 1;
    if (ntx == 0)  v[2] = 1;
    if (nrx == 64) v[1] = 1;
    if (nrx == 0)  v[0] = 1;
    return v;
  endfunction

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 0; csr_wdata = 0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic fill(input int nrx, input int ntx, input logic [7:0] base);
    for (int i = 0; i < 64; i++) begin
      if (i >= nrx && i >= ntx) break;
      @(negedge clk);
      rxw_valid = (i < nrx); rxw_data = base + 8'(i);
      txw_valid = (i < ntx); txw_data = base + 8'(i);
    end
    @(negedge clk); rxw_valid = 0; txw_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, r); chk("R1 status", r, 32'h0040_0005);
    rd(1, r); chk("R1 ctl", r, 0);
    chk("R1 dma req", {tx_dma_req, rx_dma_req}, 0);

    // R9 R10 R3 vector walk
    foreach (VECS[k]) begin
      wr(0, 32'h0000_C000);
      @(negedge clk);
      fill(int'(VECS[k].nrx), int'(VECS[k].ntx), 8'h40);
      wr(1, 32'(VECS[k].ctl));
      rd(1, r); chk("R9 ctl readback", r, 32'(VECS[k].ctl));
      rd(0, r); chk("R3 status counts", r, exp_stat(int'(VECS[k].nrx), int'(VECS[k].ntx)));
      chk("R10 rx req", 32'(rx_dma_req), 32'(VECS[k].erx));
      chk("R10 tx req", 32'(tx_dma_req), 32'(VECS[k].etx));
    end
    wr(1, 0);
    wr(0, 32'h0000_C000);
    @(negedge clk);

    // R2 order through transmit queue
    fill(0, 3, 8'hA1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); txr_ready = 1; #1;
      chk("R2 tx order", {23'b0, txr_valid, txr_data}, {23'b0, 1'b1, 8'hA1 + 8'(i)});
      @(negedge clk); txr_ready = 0;
    end

    // R4 R5 fill receive queue and overflow
    fill(64, 0, 8'h10);
    rd(0, r); chk("R4 rx full", r, exp_stat(64, 0));
    chk("R4 rxw_ready low", 32'(rxw_ready), 0);
    @(negedge clk); rxw_valid = 1; rxw_data = 8'hEE;
    @(negedge clk); rxw_valid = 0;
    rd(0, r); chk("R5 R7 overflow", r, exp_stat(64, 0) | 32'h120);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); rxr_ready = 1; #1;
      chk("R5 rx contents", 32'(rxr_data), 32'(8'h10 + 8'(i)));
      @(negedge clk); rxr_ready = 0;
    end
    // R6 underrun
    @(negedge clk); rxr_ready = 1; #1;
    chk("R6 empty pop zero", {23'b0, rxr_valid, rxr_data}, 0);
    @(negedge clk); rxr_ready = 0;
    rd(0, r); chk("R6 underrun flag", r, exp_stat(0, 0) | 32'h130);
    wr(0, 32'h20);
    rd(0, r); chk("R7 clear ovf", r, exp_stat(0, 0) | 32'h110);
    wr(0, 32'h10);
    rd(0, r); chk("R7 clear all", r, exp_stat(0, 0));
    // R7 set wins over clear
    @(negedge clk); rxr_ready = 1; csr_we = 1; csr_addr = 0; csr_wdata = 32'h10;
    @(negedge clk); rxr_ready = 0; csr_we = 0; csr_wdata = 0;
    rd(0, r); chk("R7 set wins", r, exp_stat(0, 0) | 32'h110);
    wr(0, 32'h100);
    rd(0, r); chk("R7 err clears all", r, exp_stat(0, 0));

    // R8 flush
    fill(2, 5, 8'h70);
    wr(0, 32'h0000_4000);
    txw_valid = 1; txw_data = 8'h55;
    rd(0, r); chk("R8 flush pending", r, exp_stat(2, 5) | 32'h4000);
    @(negedge clk); txw_valid = 0;
    rd(0, r); chk("R8 flush done", r, exp_stat(2, 0));
    @(negedge clk); rxr_ready = 1; #1;
    chk("R8 rx untouched", 32'(rxr_data), 32'h70);
    @(negedge clk); rxr_ready = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule